// File: doc/BRIEF.md
# Serial Converter Output Shifter

This block is the digital side of a 12-bit serial converter, seen from the converter. It watches an active-low chip select and a serial clock, both sampled on a fast system clock. When chip select falls, it captures the parallel 12-bit sample and starts a conversion. It then shifts out a 16-bit frame on a data output that can be switched off: four zeros first, then the sample with the most significant bit first. An output-enable signal travels next to the data bit, and the data bit reads 0 whenever the enable is low.

Alongside the frame, the block tracks three conditions:
- whether a conversion is in progress;
- whether the acquisition point was reached;
- whether the previous cycle was cut short before acquisition.

A cut-short cycle makes the next frame carry no valid data, so that frame shifts out all zeros. A bus master uses the block by lowering chip select and giving sixteen serial clock falling edges. It keeps chip select low at least until the serial clock rises after the thirteenth falling edge. Raising chip select earlier aborts the frame.

All events are detected by comparing each input with its value one system clock earlier. Every output is registered.

Top module: `adc_frame_shifter`

## Requirements
- R1: After reset, sdo_oe, sdo, converting, acquiring and data_invalid are all 0.
- R2: One system clock after a chip-select falling edge is sampled, sdo_oe is 1, sdo is 0 (the first leading zero), converting is 1 and acquiring is 0.
- R3: After the k-th serial clock falling edge (k from 1 to 15) with chip select low, sdo carries bit 15-k of the frame {4'b0000, sample}. The sample is the value captured at the chip-select fall. So edges 1 to 3 give 0, edge 4 gives sample bit 11 and edge 15 gives sample bit 0. Changes on the sample input after the capture have no effect on the frame.
- R4: On the 16th serial clock falling edge, sdo_oe and converting go to 0.
- R5: acquiring becomes 1 on the first serial clock rising edge after the 13th falling edge, provided chip select is still low. It stays 1 until the next chip-select fall.
- R6: A chip-select rise while a frame is open drives sdo_oe and converting to 0 one system clock later, whatever the edge count.
- R7: A chip-select rise before acquiring is 1 sets data_invalid. While data_invalid is 1, the next frame shifts out 16 zeros.
- R8: A chip-select rise after acquiring became 1 clears data_invalid. The frame after that carries the sample again.
- R9: The falling-edge count restarts on every chip-select fall and stops at 16. Further serial clock edges, and any serial clock activity while chip select is high, leave every output unchanged.
- R10: sdo is 0 whenever sdo_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| sclk | input | 1 | Serial clock, synchronous to clk |
| sample | input | 12 | Parallel sample value to capture |
| sdo | output | 1 | Serial data bit, 0 when not enabled |
| sdo_oe | output | 1 | Output enable for sdo |
| converting | output | 1 | Conversion in progress |
| acquiring | output | 1 | Acquisition point reached in this cycle |
| data_invalid | output | 1 | Previous cycle aborted before acquisition |

## Verification
Each edge on cs_n or sclk is seen at the first system clock edge where the new level is sampled. Every result is due at exactly that same clock edge: the frame bit, the enable, and the conversion, acquisition and invalid flags. Nothing is delayed further.

The bench changes inputs on the falling system clock edge. It reads outputs on the next falling edge, one full register stage after the stimulus. A behavioural reference model advances on each rising edge and is compared on every clock. Per-edge checks in the frame task count the serial clock edges themselves and name the bit expected at each one.

// File: rtl/adcfs_pkg.sv
package adcfs_pkg;

  // Pair of single-cycle pulses marking level changes of a sampled input.
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

endpackage

// File: rtl/adcfs_edge_detect.sv
module adcfs_edge_detect #(
  parameter logic INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  output adcfs_pkg::edge_t  ev
);

  logic q;

  always_ff @(posedge clk) begin
    if (rst) q <= INIT;
    else     q <= din;
  end

  assign ev.rise = din & ~q;
  assign ev.fall = ~din & q;

endmodule

// File: rtl/adcfs_fall_counter.sv
module adcfs_fall_counter #(
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic             active,
  input  logic             sclk_fall,
  output logic [CNT_W-1:0] cnt,
  output logic             fall_fire,
  output logic             last_fall
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  // A falling edge counts only inside an open frame and below saturation.
  assign fall_fire = active & sclk_fall & ~abort & (cnt != FULL);
  assign last_fall = fall_fire & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (start)     cnt <= '0;
    else if (fall_fire) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/adcfs_shifter.sv
module adcfs_shifter #(
  parameter int DATA_W = 12,
  parameter int LEAD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic              fall_fire,
  input  logic              last_fall,
  input  logic              blank,
  input  logic [DATA_W-1:0] sample,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int FRAME_W = DATA_W + LEAD_W;

  logic [FRAME_W-1:0] sh;
  logic               oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      oe_q <= 1'b0;
    end else if (start) begin
      sh   <= blank ? '0 : {{LEAD_W{1'b0}}, sample};
      oe_q <= 1'b1;
    end else if (abort) begin
      sh   <= '0;
      oe_q <= 1'b0;
    end else if (fall_fire) begin
      sh <= {sh[FRAME_W-2:0], 1'b0};
      if (last_fall) oe_q <= 1'b0;
    end
  end

  // After the final shift the register holds only zeros, so sdo is 0 when disabled.
  assign sdo    = sh[FRAME_W-1];
  assign sdo_oe = oe_q;

endmodule

// File: rtl/adcfs_tracker.sv
module adcfs_tracker #(
  parameter int CNT_W    = 5,
  parameter int ACQ_EDGE = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cs_rise,
  input  logic             sclk_rise,
  input  logic             last_fall,
  input  logic [CNT_W-1:0] cnt,
  output logic             active,
  output logic             converting,
  output logic             acquiring,
  output logic             data_invalid
);

  localparam logic [CNT_W-1:0] ACQ_CNT = CNT_W'(ACQ_EDGE);

  always_ff @(posedge clk) begin
    if (rst) begin
      active       <= 1'b0;
      converting   <= 1'b0;
      acquiring    <= 1'b0;
      data_invalid <= 1'b0;
    end else if (start) begin
      active     <= 1'b1;
      converting <= 1'b1;
      acquiring  <= 1'b0;
    end else if (cs_rise && active) begin
      active       <= 1'b0;
      converting   <= 1'b0;
      data_invalid <= ~acquiring;
    end else begin
      if (last_fall) converting <= 1'b0;
      if (active && sclk_rise && (cnt >= ACQ_CNT)) acquiring <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter #(
  parameter int DATA_W   = 12,
  parameter int LEAD_W   = 4,
  parameter int ACQ_EDGE = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              converting,
  output logic              acquiring,
  output logic              data_invalid
);

  localparam int FRAME_W = DATA_W + LEAD_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  adcfs_pkg::edge_t cs_ev;
  adcfs_pkg::edge_t sclk_ev;
  logic             active;
  logic             abort;
  logic [CNT_W-1:0] cnt;
  logic             fall_fire;
  logic             last_fall;

  adcfs_edge_detect #(.INIT(1'b1)) u_cs_edge (
    .clk (clk),
    .rst (rst),
    .din (cs_n),
    .ev  (cs_ev)
  );

  adcfs_edge_detect #(.INIT(1'b0)) u_sclk_edge (
    .clk (clk),
    .rst (rst),
    .din (sclk),
    .ev  (sclk_ev)
  );

  assign abort = cs_ev.rise & active;

  adcfs_fall_counter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .start     (cs_ev.fall),
    .abort     (abort),
    .active    (active),
    .sclk_fall (sclk_ev.fall),
    .cnt       (cnt),
    .fall_fire (fall_fire),
    .last_fall (last_fall)
  );

  adcfs_shifter #(.DATA_W(DATA_W), .LEAD_W(LEAD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (cs_ev.fall),
    .abort     (abort),
    .fall_fire (fall_fire),
    .last_fall (last_fall),
    .blank     (data_invalid),
    .sample    (sample),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
  );

  adcfs_tracker #(.CNT_W(CNT_W), .ACQ_EDGE(ACQ_EDGE)) u_track (
    .clk          (clk),
    .rst          (rst),
    .start        (cs_ev.fall),
    .cs_rise      (cs_ev.rise),
    .sclk_rise    (sclk_ev.rise),
    .last_fall    (last_fall),
    .cnt          (cnt),
    .active       (active),
    .converting   (converting),
    .acquiring    (acquiring),
    .data_invalid (data_invalid)
  );

endmodule

// File: rtl/adcfs_checker.sv
module adcfs_checker (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sdo,
  input logic sdo_oe,
  input logic converting,
  input logic acquiring,
  input logic data_invalid
);

  p_start_opens_frame_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |=> (sdo_oe && converting && !sdo && !acquiring));

  p_conv_needs_oe_r4: assert property (@(posedge clk) disable iff (rst)
    converting |-> sdo_oe);

  p_acq_needs_cs_low_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(acquiring) |-> !$past(cs_n));

  p_cs_rise_closes_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> (!sdo_oe && !converting));

  p_oe_needs_cs_low_r6: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> !$past(cs_n));

  // R8: the flag also clears only on a chip-select rise.
  p_invalid_moves_on_cs_rise_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_invalid) |-> ($past(cs_n) && !$past(cs_n, 2)));

  p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe |-> !sdo);

endmodule

bind adc_frame_shifter adcfs_checker u_adcfs_checker (
  .clk          (clk),
  .rst          (rst),
  .cs_n         (cs_n),
  .sdo          (sdo),
  .sdo_oe       (sdo_oe),
  .converting   (converting),
  .acquiring    (acquiring),
  .data_invalid (data_invalid)
);

// File: tb/adc_frame_shifter_bench.sv
module adc_frame_shifter_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        cs_n;
  logic        sclk;
  logic [11:0] sample;
  logic        sdo, sdo_oe, converting, acquiring, data_invalid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  adc_frame_shifter u_adc_frame_shifter (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sample(sample),
    .sdo(sdo), .sdo_oe(sdo_oe), .converting(converting),
    .acquiring(acquiring), .data_invalid(data_invalid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on each rising clock edge.
  int m_pcs = 1, m_psclk = 0, m_active = 0, m_cnt = 0, m_frame = 0;
  int m_conv = 0, m_acq = 0, m_inv = 0;

  always @(posedge clk) begin
    int cf, cr, sf, sr;
    if (rst) begin
      m_pcs = 1; m_psclk = 0; m_active = 0; m_cnt = 0; m_frame = 0;
      m_conv = 0; m_acq = 0; m_inv = 0;
    end else begin
      cf = (m_pcs == 1 && cs_n == 0);
      cr = (m_pcs == 0 && cs_n == 1);
      sf = (m_psclk == 1 && sclk == 0);
      sr = (m_psclk == 0 && sclk == 1);
      if (cf) begin
        m_active = 1; m_cnt = 0; m_conv = 1; m_acq = 0;
        m_frame = m_inv ? 0 : int'(sample);
      end else if (cr && m_active) begin
        m_active = 0; m_conv = 0; m_inv = m_acq ? 0 : 1;
      end else if (m_active) begin
        if (sf && m_cnt < 16) begin
          m_cnt++;
          if (m_cnt == 16) m_conv = 0;
        end
        if (sr && m_cnt >= 13) m_acq = 1;
      end
      m_pcs = cs_n; m_psclk = sclk;
    end
  end

  always @(negedge clk) begin
    int e_oe, e_sdo;
    if (!rst) begin
      e_oe  = (m_active && m_cnt < 16) ? 1 : 0;
      e_sdo = e_oe ? ((m_frame >> (15 - m_cnt)) & 1) : 0;
      chk(sdo_oe == e_oe, "R6 model sdo_oe", sdo_oe, e_oe);
      chk(sdo == e_sdo, "R3 model sdo", sdo, e_sdo);
      chk(converting == m_conv, "R4 model converting", converting, m_conv);
      chk(acquiring == m_acq, "R5 model acquiring", acquiring, m_acq);
      chk(data_invalid == m_inv, "R7 model data_invalid", data_invalid, m_inv);
    end
  end

  bit exp_inv = 0;

  // One chip-select cycle with nfall serial falling edges, optionally one more rise.
  task automatic run_frame(input logic [11:0] s, input int nfall, input bit tail_rise);
    logic [11:0] fr;
    bit acq;
    fr = exp_inv ? 12'h000 : s;
    sample = s;
    cs_n = 1'b0;
    @(negedge clk);
    chk(sdo_oe == 1 && sdo == 0 && converting == 1, "R2 start", {sdo_oe, sdo, converting}, 3'b101);
    sample = ~s;  // R3: later sample changes must not reach the frame
    for (int k = 1; k <= nfall; k++) begin
      sclk = 1'b1;
      @(negedge clk); @(negedge clk);
      sclk = 1'b0;
      @(negedge clk);
      if (k <= 15) begin
        int eb;
        eb = (k < 4) ? 0 : int'(fr[15-k]);
        chk(sdo_oe == 1, "R3 oe during frame", sdo_oe, 1);
        chk(sdo == eb, "R3 frame bit", sdo, eb);
      end else if (k == 16) begin
        chk(sdo_oe == 0 && converting == 0, "R4 last edge", {sdo_oe, converting}, 0);
      end else begin
        chk(sdo_oe == 0 && sdo == 0, "R9 extra edge", {sdo_oe, sdo}, 0);
      end
      @(negedge clk);
    end
    if (tail_rise) begin
      sclk = 1'b1;
      @(negedge clk); @(negedge clk);
    end
    acq = (nfall > 13) || (nfall == 13 && tail_rise);
    chk(acquiring == acq, "R5 acquiring", acquiring, acq);
    cs_n = 1'b1;
    @(negedge clk);
    chk(sdo_oe == 0 && sdo == 0 && converting == 0, "R6 cs rise", {sdo_oe, sdo, converting}, 0);
    exp_inv = !acq;
    chk(data_invalid == exp_inv, acq ? "R8 invalid clear" : "R7 invalid set", data_invalid, exp_inv);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; sample = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({sdo_oe, sdo, converting, acquiring, data_invalid} == 0, "R1 reset",
        {sdo_oe, sdo, converting, acquiring, data_invalid}, 0);

    run_frame(12'hA5C, 19, 1'b0);   // R9: three extra edges past 16
    run_frame(12'h800, 16, 1'b0);
    run_frame(12'hFFF, 16, 1'b1);
    run_frame(12'h001, 16, 1'b0);
    run_frame(12'h3C6, 8, 1'b0);    // R6 abort mid-data, R7 set
    run_frame(12'hFFF, 16, 1'b0);   // R7 all-zero frame, R8 clear
    run_frame(12'h5A3, 16, 1'b0);   // R8 sample returns
    run_frame(12'h777, 13, 1'b0);   // R7 abort just before acquisition
    run_frame(12'h123, 13, 1'b1);   // R8 acquisition reached, then abort
    run_frame(12'hABC, 16, 1'b0);

    // R9/R10: serial clock activity while chip select is high changes nothing.
    for (int i = 0; i < 6; i++) begin
      sclk = ~sclk;
      @(negedge clk);
      chk(sdo_oe == 0 && sdo == 0 && converting == 0, "R9 idle sclk", {sdo_oe, sdo, converting}, 0);
      chk(acquiring == 1 && data_invalid == 0, "R9 idle flags", {acquiring, data_invalid}, 2'b10);
    end
    sclk = 1'b0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule